// File: doc/BRIEF.md
# Gated Tick Timer with Pulse-Width Capture

This block is an up-counter of parameterised width that counts ticks from an internal slow timebase. The timebase is either a fast tick or a slow tick, both divided down from the system clock. In periodic mode the counter runs freely and is compared with a programmed match value. When it reaches that value it raises a one-cycle interrupt and starts again from zero. This gives a periodic interrupt of match × tick period.

In pulse mode an external input, passed through a synchronizer, gates the count. A tick is counted only while the input is at its programmed active level. The counter raises an interrupt when a gated pulse reaches the match value. With auto-clear on, the counter returns to zero when the pulse ends, so only pulses at least match ticks long ever interrupt. With auto-clear off, the counter holds the pulse length in ticks. A read of the count then returns that length and clears it. In pulse mode the count saturates at all-ones instead of wrapping.

Software reaches the block through a single-cycle write port and a combinational read port. The control register is at address 0, the match value at address 1, and the count at address 2. The count is read-only.

Top module: `gated_pulse_timer`

## Requirements
- R1: The control field `slow_sel` is at bit 0 of address 0. When it is 0, a tick falls every FAST_DIV system clocks; when it is 1, every SLOW_DIV clocks. A control write restarts the divider, so the ticks land on the k·DIV-th clock edge after the write edge (k ≥ 1). Both DIV values must be at least 2.
- R2: Periodic mode is selected by control bit 1 = 0. Each tick advances the count. When the incremented count equals the match value, the count returns to 0 and `irq` is high for exactly the one cycle after that edge.
- R3: In periodic mode a match value of 0 gives a period of 2^CW ticks.
- R4: After reset, the control, match and count read as 0 and `irq` is low. Address 0 reads back the 5 control bits zero-extended, and address 1 reads back the match value. A write to address 2 has no effect, and any control write clears the count.
- R5: Pulse mode is selected by control bit 1 = 1. The input passes through a synchronizer of SYNC_STAGES (2) flops. An input level presented at clock edge e gates the ticks at edges e+2 onward.
- R6: Control bit 2 selects a high active level and bit 3 a low one. The encoding 01 (bit 2 set only) means active-high and 10 (bit 3 set only) means active-low. With 00 or 11 the input never counts.
- R7: In pulse mode the count saturates at all-ones, so the interrupt fires at most once per pulse.
- R8: With control bit 4 (hold) at 0, the count clears on the edge after the synchronized active-to-inactive transition is seen. A pulse shorter than the match width therefore never interrupts.
- R9: With hold at 1, the count keeps the pulse length after the pulse ends. A read of address 2 with `rd_en` high clears the count at that edge. With hold at 0, such a read does not disturb the count.
- R10: In pulse mode `irq` pulses once, on the tick edge where the gated count reaches a nonzero match value. A match value of 0 never interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | CW | Write data |
| rd_en | input | 1 | Read strobe; enables the clear-on-read of the count |
| rd_addr | input | 2 | Read address |
| rd_data | output | CW | Combinational read data |
| pulse_in | input | 1 | External asynchronous pulse input |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
All timing is counted from the edge that takes the control write, called edge 0. Ticks land on edges k·DIV. Periodic mode therefore has the count equal to floor(n/DIV) mod match after edge n, and `irq` high after each edge n that is a multiple of match·DIV. In pulse mode an input held active for edges s to f−1 gates the ticks on edges s+2 to f+1. The auto-clear takes effect at edge f+2. A clear-on-read lands at the edge that samples `rd_en`. The bench drives and samples on the falling clock edge, so each sample sees the state left by exactly one rising edge. It compares against these formulas cycle by cycle.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_MATCH = 2'd1;
  localparam logic [ADDR_W-1:0] A_COUNT = 2'd2;

  typedef struct packed {
    logic hold;        // bit 4: keep count after pulse end
    logic act_lo;      // bit 3: active-low gate
    logic act_hi;      // bit 2: active-high gate
    logic pulse_mode;  // bit 1: input-gated mode
    logic slow_sel;    // bit 0: slow timebase
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int FAST_DIV = 2000,
  parameter int SLOW_DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic slow_sel,
  output logic tick
);
  localparam int MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int PCW     = $clog2(MAX_DIV);

  logic [PCW-1:0] pcnt_q, pcnt_d, limit;
  logic           wrap;

  assign limit = slow_sel ? PCW'(SLOW_DIV - 1) : PCW'(FAST_DIV - 1);
  assign wrap  = (pcnt_q >= limit);
  assign tick  = wrap && !restart;

  always_comb begin
    pcnt_d = pcnt_q;
    if (restart)   pcnt_d = '0;
    else if (wrap) pcnt_d = '0;
    else           pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick) else $error("tick on consecutive cycles"); // R1
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick) else $error("tick right after restart"); // R1
endmodule

// File: rtl/gpt_sync.sv
module gpt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], din};
  end

  assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/gpt_core.sv
module gpt_core #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          gate,
  input  logic          pulse_mode,
  input  logic          hold,
  input  logic          clr_req,
  input  logic          rd_clr,
  input  logic [CW-1:0] match,
  output logic [CW-1:0] cnt,
  output logic          irq
);
  localparam logic [CW-1:0] ALL1 = '1;

  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic          irq_q, irq_d, gate_q, pend;

  assign cnt_inc = cnt_q + 1'b1;
  assign pend    = gate_q && !gate;

  always_comb begin
    cnt_d = cnt_q;
    irq_d = 1'b0;
    if (clr_req || rd_clr) begin
      cnt_d = '0;
    end else if (pulse_mode) begin
      if (pend && !hold) begin
        cnt_d = '0;
      end else if (tick && gate && (cnt_q != ALL1)) begin
        cnt_d = cnt_inc;
        irq_d = (cnt_inc == match);
      end
    end else if (tick) begin
      if (cnt_inc == match) begin
        cnt_d = '0;
        irq_d = 1'b1;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      irq_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      irq_q  <= irq_d;
      gate_q <= gate;
    end
  end

  assign cnt = cnt_q;
  assign irq = irq_q;

  AST_IRQ_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(tick)) else $error("irq without tick"); // R2
  AST_PERIODIC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !pulse_mode) |-> (cnt_q == '0)) else $error("no restart on match"); // R2
  AST_GATE_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && !gate && !gate_q && !clr_req && !rd_clr) |=> $stable(cnt_q))
    else $error("count moved with gate off"); // R5
  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && cnt_q == ALL1 && !clr_req && !rd_clr && !(pend && !hold)) |=> (cnt_q == ALL1))
    else $error("saturated count left all-ones"); // R7
  AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && pend && !hold) |=> (cnt_q == '0)) else $error("no auto clear"); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> (cnt_q == '0)) else $error("read did not clear"); // R9
endmodule

// File: rtl/gated_pulse_timer.sv
module gated_pulse_timer
  import gpt_pkg::*;
#(
  parameter int CW          = 8,
  parameter int FAST_DIV    = 2000,
  parameter int SLOW_DIV    = 50000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CW-1:0]     rd_data,
  input  logic              pulse_in,
  output logic              irq
);
  logic [1:0]    rst_sq;
  logic          rst_i;
  ctrl_t         ctrl_q, ctrl_d;
  logic [CW-1:0] match_q, match_d, cnt;
  logic          wr_ctrl, wr_match, rd_clr, tick, pin_s, gate;

  // reset: asserted asynchronously, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= '0;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_i = rst_sq[1];

  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign wr_match = wr_en && (wr_addr == A_MATCH);
  assign rd_clr   = rd_en && (rd_addr == A_COUNT) && ctrl_q.hold;

  always_comb begin
    ctrl_d  = wr_ctrl  ? ctrl_t'(wr_data[CTRL_W-1:0]) : ctrl_q;
    match_d = wr_match ? wr_data : match_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl_q  <= '0;
      match_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      match_q <= match_d;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = CW'(ctrl_q);
      A_MATCH: rd_data = match_q;
      A_COUNT: rd_data = cnt;
      default: rd_data = '0;
    endcase
  end

  gpt_prescaler #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_presc (
    .clk(clk), .rst_n(rst_i), .restart(wr_ctrl), .slow_sel(ctrl_q.slow_sel), .tick(tick)
  );

  gpt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i), .din(pulse_in), .dout(pin_s)
  );

  assign gate = ( ctrl_q.act_hi && !ctrl_q.act_lo &&  pin_s) ||
                (!ctrl_q.act_hi &&  ctrl_q.act_lo && !pin_s);

  gpt_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_i), .tick(tick), .gate(gate),
    .pulse_mode(ctrl_q.pulse_mode), .hold(ctrl_q.hold),
    .clr_req(wr_ctrl), .rd_clr(rd_clr), .match(match_q),
    .cnt(cnt), .irq(irq)
  );

  AST_CTRL_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_i)
    wr_ctrl |=> (cnt == '0 && !irq)) else $error("control write left count"); // R4
  AST_BAD_POLARITY_IDLE: assert property (@(posedge clk) disable iff (!rst_i)
    (ctrl_q.act_hi == ctrl_q.act_lo) |-> !gate) else $error("gate with invalid polarity"); // R6
endmodule

// File: tb/tb_gated_pulse_timer.sv
module tb_gated_pulse_timer;
  localparam int FD = 3;
  localparam int SD = 5;

  logic       clk = 1'b0;
  logic       rst_n, wr_en, rd_en, pulse_in, irq;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  gated_pulse_timer #(.CW(8), .FAST_DIV(FD), .SLOW_DIV(SD), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pulse_in(pulse_in), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // ends at the falling edge after the write edge (edge 0)
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output int v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  function automatic int gated_ticks(input int s, input int f, input int d);
    int c = 0;
    for (int k = 1; k * d <= f + 1; k++) if (k * d >= s + 2) c++;
    return c;
  endfunction

  task automatic run_timer(input int m, input bit slow);
    int d, mef;
    d   = slow ? SD : FD;
    mef = (m == 0) ? 256 : m;
    wr(2'd1, 8'(m));
    wr(2'd0, {7'b0, slow});
    rd_en = 1'b1; rd_addr = 2'd2;   // hold=0: reads must not clear (R9)
    for (int n = 1; n <= 2 * mef * d + 1; n++) begin
      @(negedge clk); #1;
      chk("R2 R3 irq", irq, (n % (mef * d) == 0) ? 1 : 0);
      chk("R1 R9 count", rd_data, (n / d) % mef);
    end
    rd_en = 1'b0;
  endtask

  task automatic run_pulse(input string tag, input logic [7:0] ctrl, input int m,
                           input int s, input int len, input bit act, input bit valid);
    int d, f, raw, irqs, v;
    d = ctrl[0] ? SD : FD;
    f = s + len;
    irqs = 0;
    wr(2'd1, 8'(m));
    pulse_in = !act;
    repeat (4) @(negedge clk);
    wr(2'd0, ctrl);
    for (int n = 0; n <= f + 4; n++) begin
      if (n > 0 && irq) irqs++;
      pulse_in = (n + 1 >= s && n + 1 < f) ? act : !act;
      @(negedge clk);
    end
    raw = valid ? gated_ticks(s, f, d) : 0;
    chk({tag, " R10 irq count"}, irqs, (m != 0 && raw >= m) ? 1 : 0);
    peek(2'd2, v);
    chk({tag, " count after pulse"}, v, ctrl[4] ? ((raw > 255) ? 255 : raw) : 0);
    if (ctrl[4]) begin
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      peek(2'd2, v);
      chk("R9 clear on read", v, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: run hung, got 0 expected 1");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int v;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; pulse_in = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4 reset state and register access
    peek(2'd0, v); chk("R4 reset ctrl", v, 0);
    peek(2'd1, v); chk("R4 reset match", v, 0);
    peek(2'd2, v); chk("R4 reset count", v, 0);
    chk("R4 reset irq", irq, 0);
    wr(2'd0, 8'h1D); peek(2'd0, v); chk("R4 ctrl readback", v, 8'h1D);
    wr(2'd0, 8'hFF); peek(2'd0, v); chk("R4 ctrl width", v, 8'h1F);
    wr(2'd1, 8'hA5); peek(2'd1, v); chk("R4 match readback", v, 8'hA5);
    wr(2'd0, 8'h02);
    wr(2'd2, 8'h77); peek(2'd2, v); chk("R4 count write ignored", v, 0);

    // R1 R2: periodic sweep over both timebases
    for (int sl = 0; sl < 2; sl++)
      for (int m = 1; m <= 8; m++) run_timer(m, sl[0]);
    run_timer(0, 1'b0);  // R3

    // R5 R8 R9 R10: gate-length sweeps, active high
    for (int len = 0; len <= 30; len++) begin
      run_pulse("R5 R9", 8'h16, 4, 3, len, 1'b1, 1'b1);
      run_pulse("R5 R8", 8'h06, 4, 3, len, 1'b1, 1'b1);
    end
    // R6 active low
    for (int len = 0; len <= 20; len++) begin
      run_pulse("R6 low hold", 8'h1A, 3, 5, len, 1'b0, 1'b1);
      run_pulse("R6 low clear", 8'h0A, 3, 5, len, 1'b0, 1'b1);
    end
    run_pulse("R1 slow", 8'h17, 2, 2, 25, 1'b1, 1'b1);
    run_pulse("R6 pol 00", 8'h12, 1, 3, 20, 1'b1, 1'b0);
    run_pulse("R6 pol 11", 8'h1E, 1, 3, 20, 1'b0, 1'b0);
    // R7 saturation
    run_pulse("R7 sat", 8'h16, 200, 3, 900, 1'b1, 1'b1);
    run_pulse("R7 sat m255", 8'h16, 255, 3, 900, 1'b1, 1'b1);
    run_pulse("R10 m0", 8'h16, 0, 3, 60, 1'b1, 1'b1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule